// File: doc/BRIEF.md
# Register-Mapped Serial Flash Word Reader

This block sits between a simple 32-bit register bus and a four-wire serial configuration flash. It spares the host from toggling flash pins. The host first writes a 24-bit flash address and a length field. The length field holds the number of bytes wanted minus one. The host then sets the start bit in the control register. The block drives chip select low, sends the read opcode and the address, and clocks back up to four data bytes. A busy flag stays set for the whole transfer.

When busy clears, the assembled word can be read from a separate read-data window. The register set is placed at a parameterised base address. A write-data holding register also sits in the window for software that stages words. The serial clock is the system clock divided by a parameter.

Top module: `cfgflash_reader`

## Requirements
- R1: After reset the status register reads 0, the read-data window reads 0, chip select is high and the serial clock is low.
- R2: The address register at base+0x000 keeps 24 bits (the upper bits read 0). The length register at base+0x004 keeps 2 bits. The write-data register at base+0x100 reads back all 32 bits. The control register at base+0x008 reads 0.
- R3: Writing a word with bit 0 set to the control register while idle starts a transfer. Bit 0 of the status register at base+0x00C reads 1 from the next cycle until the transfer ends.
- R4: During a transfer chip select stays low throughout. Serial-out carries opcode 0x03 and then the 24 address bits, most significant bit first. Serial-out changes only while the serial clock is low.
- R5: A transfer reads length+1 bytes, so it has exactly 32 + 8*(length+1) rising serial clock edges.
- R6: The first byte returned lands in bits 7:0 of the read-data window at base+0x200, the second in bits 15:8, and so on. Bits in bytes not read are 0. Serial-in bits arrive most significant first within each byte and are sampled on the rising serial clock edge.
- R7: Each serial bit lasts DIV system clocks. Chip select is low for exactly (32 + 8*(length+1))*DIV cycles, which is at most 64*DIV cycles (about 1 us with the defaults). That is well inside 50 us.
- R8: A start written while busy is ignored. The running transfer keeps its address and length, and no second transfer follows.
- R9: A control write with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_sel is high and reg_we is low |
| fl_sck | output | 1 | Serial clock to the flash |
| fl_cs_n | output | 1 | Active-low flash chip select |
| fl_mosi | output | 1 | Serial data to the flash |
| fl_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check four things on every cycle:
- the serial clock stays low while chip select is high;
- serial-out holds still while the serial clock is high;
- a start from idle always lowers chip select, and nothing else does;
- chip select is never low for longer than the longest legal transfer.

Only the bench scenarios can show the following, because each is checked against a flash model that computes its contents from the address:
- the opcode and address bits on the wire;
- the exact edge count for each length;
- the byte placement in the read-data window;
- that a start written mid-transfer really is dropped.

// File: rtl/cfgflash_reader.sv
module cfgflash_reader #(
  parameter int AW   = 12,
  parameter int BASE = 'h300,
  parameter int DIV  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          fl_sck,
  output logic          fl_cs_n,
  output logic          fl_mosi,
  input  logic          fl_miso
);
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [AW-1:0] A_ADR = AW'(BASE);
  localparam logic [AW-1:0] A_LEN = AW'(BASE + 'h4);
  localparam logic [AW-1:0] A_CTL = AW'(BASE + 'h8);
  localparam logic [AW-1:0] A_STS = AW'(BASE + 'hC);
  localparam logic [AW-1:0] A_WIN = AW'(BASE + 'h100);
  localparam logic [AW-1:0] A_RIN = AW'(BASE + 'h200);

  logic [23:0]   addr_q;
  logic [1:0]    len_q, run_len_q;
  logic [31:0]   wbuf_q, rbuf_q, sh_q;
  logic          busy_q;
  logic [PW-1:0] ph_q;
  logic [6:0]    bit_q;

  logic       wr, go, tick, samp, last;
  logic [4:0] pos;

  assign wr   = reg_sel && reg_we;
  assign go   = wr && (reg_addr == A_CTL) && reg_wdata[0] && !busy_q;
  assign tick = ph_q == PW'(DIV - 1);
  assign samp = ph_q == PW'(HALF);
  assign last = bit_q == (7'd39 + {2'b00, run_len_q, 3'b000});
  assign pos  = {bit_q[4:3], ~bit_q[2:0]};

  assign fl_cs_n = ~busy_q;
  assign fl_sck  = busy_q && (ph_q >= PW'(HALF));
  assign fl_mosi = busy_q && sh_q[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      len_q     <= '0;
      run_len_q <= '0;
      wbuf_q    <= '0;
      rbuf_q    <= '0;
      sh_q      <= '0;
      busy_q    <= 1'b0;
      ph_q      <= '0;
      bit_q     <= '0;
    end else begin
      if (wr && reg_addr == A_ADR) addr_q <= reg_wdata[23:0];
      if (wr && reg_addr == A_LEN) len_q  <= reg_wdata[1:0];
      if (wr && reg_addr == A_WIN) wbuf_q <= reg_wdata;
      if (go) begin
        busy_q    <= 1'b1;
        ph_q      <= '0;
        bit_q     <= '0;
        sh_q      <= {8'h03, addr_q};
        rbuf_q    <= '0;
        run_len_q <= len_q;
      end else if (busy_q) begin
        ph_q <= tick ? '0 : ph_q + 1'b1;
        if (samp && bit_q >= 7'd32) rbuf_q[pos] <= fl_miso;
        if (tick) begin
          sh_q  <= {sh_q[30:0], 1'b0};
          bit_q <= bit_q + 7'd1;
          if (last) busy_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && !reg_we) begin
      case (reg_addr)
        A_ADR:   reg_rdata = {8'h00, addr_q};
        A_LEN:   reg_rdata = {30'd0, len_q};
        A_STS:   reg_rdata = {31'd0, busy_q};
        A_WIN:   reg_rdata = wbuf_q;
        A_RIN:   reg_rdata = rbuf_q;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfgflash_reader_chk.sv
module cfgflash_reader_chk #(
  parameter int AW   = 12,
  parameter int BASE = 'h300,
  parameter int DIV  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_sel,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          fl_sck,
  input logic          fl_cs_n,
  input logic          fl_mosi
);
  localparam logic [AW-1:0] A_CTL = AW'(BASE + 'h8);
  localparam int MAXC = 64 * DIV;

  logic start_wr;
  int   lowc;

  assign start_wr = reg_sel && reg_we && (reg_addr == A_CTL) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowc <= 0;
    else if (!fl_cs_n) lowc <= lowc + 1;
    else lowc <= 0;
  end

  a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> !fl_sck);

  a_r3_start_lowers_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cs_n && start_wr) |=> !fl_cs_n);

  a_r9_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cs_n && !start_wr) |=> fl_cs_n);

  a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_cs_n && fl_sck && $past(fl_sck)) |-> $stable(fl_mosi));

  a_r7_cs_window: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_cs_n |-> lowc < MAXC);
endmodule

bind cfgflash_reader cfgflash_reader_chk #(.AW(AW), .BASE(BASE), .DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .fl_sck(fl_sck),
  .fl_cs_n(fl_cs_n), .fl_mosi(fl_mosi)
);

// File: tb/cfgflash_reader_bench.sv
module cfgflash_reader_bench;
  localparam int AW = 12;
  localparam int DIV = 4;
  localparam logic [11:0] A_ADR = 12'h300, A_LEN = 12'h304, A_CTL = 12'h308,
                          A_STS = 12'h30C, A_WIN = 12'h400, A_RIN = 12'h500;

  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic fl_sck, fl_cs_n, fl_mosi;
  logic fl_miso = 0;

  int nchk = 0, nfail = 0, lowcyc = 0, rises = 0, fcnt = 0;
  logic [31:0] fcmd = '0;

  cfgflash_reader #(.AW(AW), .BASE('h300), .DIV(DIV)) u_cfgflash_reader (.*);

  always #2 clk = ~clk;

  function automatic logic [7:0] membyte(input logic [23:0] a);
    return 8'((a[7:0] * 7 + a[15:8] * 3 + a[23:16]) ^ 8'hA5);
  endfunction

  always @(negedge fl_cs_n) begin fcnt = 0; rises = 0; fcmd = '0; end
  always @(posedge fl_sck) begin
    if (fcnt < 32) fcmd = {fcmd[30:0], fl_mosi};
    fcnt++; rises++;
  end
  always @(negedge fl_sck) if (fcnt >= 32) begin
    automatic int d = fcnt - 32;
    automatic logic [7:0] b = membyte(fcmd[23:0] + 24'(d / 8));
    fl_miso = b[7 - (d % 8)];
  end
  always @(negedge clk) if (!fl_cs_n) lowcyc++;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bw(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_we = 0;
  endtask

  task automatic br(input logic [11:0] a, output logic [31:0] v);
    reg_sel = 1; reg_we = 0; reg_addr = a;
    #1 v = reg_rdata;
    reg_sel = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      br(A_STS, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  function automatic logic [31:0] expw(input logic [23:0] a, input int n);
    logic [31:0] w = '0;
    for (int k = 0; k < n; k++) w[8*k +: 8] = membyte(a + 24'(k));
    return w;
  endfunction

  task automatic run_read(input logic [23:0] a, input int len);
    logic [31:0] v;
    int n = len + 1;
    bw(A_ADR, {8'h00, a});
    bw(A_LEN, 32'(len));
    lowcyc = 0;
    bw(A_CTL, 32'h1);
    br(A_STS, v);
    chk("R3 busy after start", v, 32'h1);
    wait_idle();
    chk("R4 opcode+address", fcmd, {8'h03, a});
    chk("R5 rising edges", 32'(rises), 32'(32 + 8 * n));
    chk("R7 cs low cycles", 32'(lowcyc), 32'((32 + 8 * n) * DIV));
    br(A_RIN, v);
    chk("R6 read word", v, expw(a, n));
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    logic [23:0] adrs [6];
    adrs = '{24'h000000, 24'hFFFFFF, 24'hFFFFFE, 24'h7F0000, 24'h123456, 24'hA5C3E1};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    br(A_STS, v); chk("R1 status reset", v, 32'h0);
    br(A_RIN, v); chk("R1 read window reset", v, 32'h0);
    chk("R1 cs_n reset", {31'd0, fl_cs_n}, 32'h1);
    chk("R1 sck reset", {31'd0, fl_sck}, 32'h0);

    bw(A_ADR, 32'hFFFFFFFF); br(A_ADR, v); chk("R2 address width", v, 32'h00FFFFFF);
    bw(A_LEN, 32'hFFFFFFFF); br(A_LEN, v); chk("R2 length width", v, 32'h3);
    bw(A_WIN, 32'hDEADBEEF); br(A_WIN, v); chk("R2 write window", v, 32'hDEADBEEF);
    br(A_CTL, v); chk("R2 control reads 0", v, 32'h0);

    for (int len = 0; len < 4; len++)
      for (int i = 0; i < 6; i++) run_read(adrs[i], len);

    // R9: control write with bit 0 clear
    lowcyc = 0;
    bw(A_CTL, 32'hFFFFFFFE);
    repeat (10) @(negedge clk);
    chk("R9 no transfer lowcyc", 32'(lowcyc), 32'h0);
    br(A_STS, v); chk("R9 status idle", v, 32'h0);

    // R8: second start while busy
    bw(A_ADR, 32'h00ABCDEF);
    bw(A_LEN, 32'h3);
    lowcyc = 0;
    bw(A_CTL, 32'h1);
    repeat (20) @(negedge clk);
    bw(A_ADR, 32'h00111111);
    bw(A_LEN, 32'h0);
    bw(A_CTL, 32'h1);
    wait_idle();
    chk("R8 address kept", fcmd, 32'h03ABCDEF);
    chk("R8 length kept", 32'(rises), 32'd64);
    chk("R8 cs low cycles", 32'(lowcyc), 32'(64 * DIV));
    br(A_RIN, v); chk("R8 data of first read", v, expw(24'hABCDEF, 4));
    lowcyc = 0;
    repeat (30) @(negedge clk);
    chk("R8 no follow-on transfer", 32'(lowcyc), 32'h0);
    br(A_ADR, v); chk("R8 address reg updated", v, 32'h00111111);
    finish_up();
  end
endmodule